// File: doc/BRIEF.md
# Grouped GPIO Interrupt Controller

This block gathers interrupt sources from up to 128 GPIO pins, plus a timer match event and a cable-detect signal, into seven groups of 32 bits. Each group raises its own request line. Every source bit has its own trigger type, either edge or level, and its own polarity. Every source is first synchronised to the block clock. A status bit latches each detected event, and software clears it by writing a one to that bit.

Software reaches four register banks (polarity, status, enable, type) through a word-addressed bus with separate read and write strobes. Pins map to groups in reverse order, and the four byte lanes inside a group are also reversed. Bit positions that are not implemented are hard-wired to zero. A group's request line goes high while any enabled status bit of that group is set.

Top module: `gic_top`

## Requirements
- R1: After reset every polarity, status, enable and type bit reads 0 and all seven `irq_out` bits are low.
- R2: Register word addresses are 0x20+g (polarity), 0x28+g (status), 0x30+g (enable) and 0x38+g (type) for group g in 0..6; these are the byte offsets 0x80/0xA0/0xC0/0xE0 plus 4g divided by four. Address bits [5:3] select the bank and bits [2:0] select the group. Polarity, enable and type bits read back as written. Group index 7, any address below 0x20, and any cycle with `reg_rd` low all read 0.
- R3: Type bit 0 selects edge and type bit 1 selects level. Polarity bit 1 selects rising edge or high level, and polarity bit 0 selects falling edge or low level. Each input passes through a two-flop synchroniser and its edge detector, so a status bit is set on the third rising clock edge after the input changes, and never without a detected event.
- R4: Writing 1 to a status bit clears it; writing 0 leaves it unchanged.
- R5: In level mode the status bit is set again on every cycle the active level holds, so a clear only sticks once the input is inactive. When a set and a clear of the same bit fall in the same cycle, the set wins.
- R6: `irq_out[6-g]` is high exactly when status AND enable of group g is non-zero. Clearing the enable drops the line but leaves the status bit set.
- R7: GPIO pin n feeds group 6-(n>>5) at bit (24-(n&24)) | (n&7).
- R8: Unimplemented bits always read 0, ignore writes and never set. These are group 3 bits 28..31, all of groups 1 and 2, and every group 0 bit except bits 0 and 2.
- R9: Group 0 bit 0 is driven by `timer_match_in`, and group 0 bit 2 by `cable_det_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gpio_in | input | 128 | Raw GPIO pin levels, asynchronous |
| timer_match_in | input | 1 | Always-on timer match event |
| cable_det_in | input | 1 | Cable-detect level |
| reg_addr | input | 6 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq_out | output | 7 | Request lines, bit 6-g belongs to group g |

## Verification
The assertions check on every cycle the following:
- an event detected this cycle always appears in status on the next cycle, even when a clear is written at the same moment;
- a write-one clears exactly the bits that had no new event;
- no status bit rises without a detected event;
- masked positions never hold a one.

Other behaviours need the bench's scenarios to show them:
- the reversed pin-to-group and lane mapping, swept across all 128 pins;
- the synchroniser latency;
- level re-assertion across a clear;
- falling and low polarities;
- enable gating of the request line;
- the readback of hard-masked enables.

// File: rtl/gic_pkg.sv
package gic_pkg;
  localparam int GRP_W   = 32;
  localparam int NUM_GRP = 7;
  localparam int GRP_AW  = 3;

  typedef enum logic [2:0] {
    BANK_POL  = 3'd4,
    BANK_STAT = 3'd5,
    BANK_EN   = 3'd6,
    BANK_TYPE = 3'd7
  } bank_e;

  // implemented bit positions of each group
  function automatic logic [GRP_W-1:0] impl_mask(input int g);
    case (g)
      0:       impl_mask = 32'h0000_0005;
      1, 2:    impl_mask = 32'h0000_0000;
      3:       impl_mask = 32'h0FFF_FFFF;
      default: impl_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  // group fed by a linear pin number (reverse order)
  function automatic int pin_group(input int n);
    pin_group = NUM_GRP - 1 - (n >> 5);
  endfunction

  // bit inside the group, byte lanes reversed
  function automatic int pin_bit(input int n);
    pin_bit = (24 - (n & 24)) | (n & 7);
  endfunction
endpackage

// File: rtl/gic_sync.sv
module gic_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [STAGES-1:0][W-1:0] stage_q;
  logic [STAGES-1:0][W-1:0] stage_d;

  always_comb begin
    stage_d[0] = d_in;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/gic_group.sv
module gic_group #(
  parameter int               W    = 32,
  parameter logic [W-1:0]     MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_s,
  input  logic         wr_pol,
  input  logic         wr_stat,
  input  logic         wr_en,
  input  logic         wr_type,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pol_o,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] type_o,
  output logic         irq_o
);
  logic [W-1:0] pol_q, pol_d, stat_q, stat_d, en_q, en_d, type_q, type_d;
  logic [W-1:0] prev_q;
  logic [W-1:0] rise, fall, edge_hit, lvl_hit, hit, clr;

  // event detection
  always_comb begin
    rise     = src_s & ~prev_q;
    fall     = ~src_s & prev_q;
    edge_hit = (pol_q & rise) | (~pol_q & fall);
    lvl_hit  = (pol_q & src_s) | (~pol_q & ~src_s);
    hit      = ((type_q & lvl_hit) | (~type_q & edge_hit)) & MASK;
    clr      = wr_stat ? wdata : '0;
  end

  // next state
  always_comb begin
    pol_d  = pol_q;
    en_d   = en_q;
    type_d = type_q;
    if (wr_pol)  pol_d  = wdata & MASK;
    if (wr_en)   en_d   = wdata & MASK;
    if (wr_type) type_d = wdata & MASK;
    stat_d = ((stat_q & ~clr) | hit) & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      stat_q <= '0;
      en_q   <= '0;
      type_q <= '0;
      prev_q <= '0;
    end else begin
      pol_q  <= pol_d;
      stat_q <= stat_d;
      en_q   <= en_d;
      type_q <= type_d;
      prev_q <= src_s;
    end
  end

  assign pol_o  = pol_q;
  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign type_o = type_q;
  assign irq_o  = |(stat_q & en_q);

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((stat_q & $past(hit)) == $past(hit))); // R5
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((stat_q & $past(wdata & ~hit)) == '0)); // R4
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((stat_q & ~$past(stat_q) & ~$past(hit)) == '0)); // R3
  AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((pol_q | stat_q | en_q | type_q) & ~MASK) == '0); // R8
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q)); // R2
endmodule

// File: rtl/gic_top.sv
module gic_top #(
  parameter int GPIO_PINS   = 128,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [GPIO_PINS-1:0]      gpio_in,
  input  logic                      timer_match_in,
  input  logic                      cable_det_in,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic                      reg_wr,
  input  logic                      reg_rd,
  input  logic [gic_pkg::GRP_W-1:0] reg_wdata,
  output logic [gic_pkg::GRP_W-1:0] reg_rdata,
  output logic [gic_pkg::NUM_GRP-1:0] irq_out
);
  import gic_pkg::*;

  localparam int SRC_W = NUM_GRP * GRP_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  // source routing
  logic [NUM_GRP-1:0][GRP_W-1:0] src_raw, src_s;
  always_comb begin
    src_raw = '0;
    for (int n = 0; n < GPIO_PINS; n++)
      src_raw[pin_group(n)][pin_bit(n)] = gpio_in[n];
    src_raw[0][0] = timer_match_in;
    src_raw[0][2] = cable_det_in;
  end

  gic_sync #(.W(SRC_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n_i),
    .d_in  (src_raw),
    .q_out (src_s)
  );

  // address decode
  logic [2:0]        bank;
  logic [GRP_AW-1:0] grp_sel;
  assign bank    = reg_addr[5:3];
  assign grp_sel = reg_addr[GRP_AW-1:0];

  logic [NUM_GRP-1:0][GRP_W-1:0] pol_v, stat_v, en_v, type_v;
  logic [NUM_GRP-1:0]            irq_g;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam logic [GRP_W-1:0] GMASK = impl_mask(g);
    logic hit_sel;
    assign hit_sel = reg_wr && (grp_sel == GRP_AW'(g));

    gic_group #(.W(GRP_W), .MASK(GMASK)) grp_i (
      .clk     (clk),
      .rst_n   (rst_n_i),
      .src_s   (src_s[g]),
      .wr_pol  (hit_sel && bank == BANK_POL),
      .wr_stat (hit_sel && bank == BANK_STAT),
      .wr_en   (hit_sel && bank == BANK_EN),
      .wr_type (hit_sel && bank == BANK_TYPE),
      .wdata   (reg_wdata),
      .pol_o   (pol_v[g]),
      .stat_o  (stat_v[g]),
      .en_o    (en_v[g]),
      .type_o  (type_v[g]),
      .irq_o   (irq_g[g])
    );

    // group g drives output 6-g
    assign irq_out[NUM_GRP-1-g] = irq_g[g];
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_rd && (int'(grp_sel) < NUM_GRP)) begin
      case (bank)
        BANK_POL:  reg_rdata = pol_v[grp_sel];
        BANK_STAT: reg_rdata = stat_v[grp_sel];
        BANK_EN:   reg_rdata = en_v[grp_sel];
        BANK_TYPE: reg_rdata = type_v[grp_sel];
        default:   reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: tb/gic_top_tb_top.sv
module gic_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [127:0] gpio_in;
  logic        timer_match_in, cable_det_in;
  logic [5:0]  reg_addr;
  logic        reg_wr, reg_rd;
  logic [31:0] reg_wdata, reg_rdata;
  logic [6:0]  irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  gic_top dut_i (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in),
    .timer_match_in(timer_match_in), .cable_det_in(cable_det_in),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  function automatic logic [31:0] exp_mask(input int g);
    if (g == 0) return 32'h5;
    if (g == 1 || g == 2) return 32'h0;
    if (g == 3) return 32'h0FFF_FFFF;
    return 32'hFFFF_FFFF;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; gpio_in = '0; timer_match_in = 0; cable_det_in = 0;
    reg_addr = '0; reg_wr = 0; reg_rd = 0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    chk("R1 irq", {25'd0, irq_out}, 32'd0);
    for (int b = 4; b < 8; b++)
      for (int g = 0; g < 7; g++) begin
        rd(6'(b*8 + g), v);
        chk("R1 reg", v, 32'd0);
      end

    // R2 / R8 programming and readback
    for (int g = 0; g < 7; g++) begin
      wr(6'(6'h20 + g), 32'hFFFF_FFFF);
      wr(6'(6'h30 + g), 32'hFFFF_FFFF);
    end
    for (int g = 0; g < 7; g++) begin
      rd(6'(6'h30 + g), v); chk("R8 enable mask", v, exp_mask(g));
      rd(6'(6'h20 + g), v); chk("R2 polarity readback", v, exp_mask(g));
    end
    rd(6'h37, v); chk("R2 group 7", v, 32'd0);
    rd(6'h05, v); chk("R2 low address", v, 32'd0);
    @(negedge clk); reg_addr = 6'h30; #1 chk("R2 no strobe", reg_rdata, 32'd0);

    // R7 / R3 / R6 / R8 sweep over all pins, rising edge
    for (int n = 0; n < 128; n++) begin
      int g, b;
      logic [31:0] e;
      g = 6 - (n >> 5);
      b = (24 - (n & 24)) | (n & 7);
      e = exp_mask(g) & (32'd1 << b);
      @(negedge clk) gpio_in[n] = 1'b1;
      settle();
      rd(6'(6'h28 + g), v);
      chk("R7 pin map status", v, e);
      chk("R6 irq line", {25'd0, irq_out}, (e != 0) ? (32'd1 << (6 - g)) : 32'd0);
      wr(6'(6'h28 + g), 32'hFFFF_FFFF);
      @(negedge clk) gpio_in[n] = 1'b0;
      settle();
      rd(6'(6'h28 + g), v);
      chk("R3 falling ignored when rising", v, 32'd0);
    end

    // R4 write of zero has no effect
    @(negedge clk) gpio_in[5] = 1'b1;  // group 6 bit 29
    settle();
    wr(6'h2E, 32'h0);
    rd(6'h2E, v); chk("R4 zero write", v, 32'h2000_0000);
    wr(6'h2E, 32'h2000_0000);
    rd(6'h2E, v); chk("R4 one clears", v, 32'd0);
    @(negedge clk) gpio_in[5] = 1'b0;
    settle();

    // R5 level high: clear while active does not stick
    wr(6'h3E, 32'h0100_0000);          // pin 0 -> group 6 bit 24 level
    @(negedge clk) gpio_in[0] = 1'b1;
    settle();
    wr(6'h2E, 32'h0100_0000);
    rd(6'h2E, v); chk("R5 level reasserts", v, 32'h0100_0000);
    @(negedge clk) gpio_in[0] = 1'b0;
    settle();
    wr(6'h2E, 32'h0100_0000);
    rd(6'h2E, v); chk("R5 clear after inactive", v, 32'd0);

    // R3 level low polarity
    wr(6'h26, 32'hFEFF_FFFF);
    settle();
    rd(6'h2E, v); chk("R3 level low", v, 32'h0100_0000);
    chk("R6 level low irq", {25'd0, irq_out}, 32'h1);
    @(negedge clk) gpio_in[0] = 1'b1;
    settle();
    wr(6'h2E, 32'h0100_0000);
    rd(6'h2E, v); chk("R3 level low released", v, 32'd0);
    wr(6'h3E, 32'h0);

    // R3 falling edge: pin 1 -> group 6 bit 25
    wr(6'h26, 32'hFDFF_FFFF);
    @(negedge clk) gpio_in[1] = 1'b1;
    settle();
    rd(6'h2E, v); chk("R3 rise ignored when falling", v & 32'h0200_0000, 32'd0);
    @(negedge clk) gpio_in[1] = 1'b0;
    settle();
    rd(6'h2E, v); chk("R3 falling edge", v, 32'h0200_0000);

    // R6 enable gating
    wr(6'h36, 32'h0);
    chk("R6 disabled line", {25'd0, irq_out}, 32'd0);
    rd(6'h2E, v); chk("R6 status kept", v, 32'h0200_0000);
    wr(6'h36, 32'hFFFF_FFFF);
    chk("R6 re-enabled line", {25'd0, irq_out}, 32'h1);
    wr(6'h2E, 32'hFFFF_FFFF);
    chk("R6 line after clear", {25'd0, irq_out}, 32'd0);

    // R9 timer match and cable detect into group 0
    @(negedge clk) timer_match_in = 1'b1;
    @(negedge clk) timer_match_in = 1'b0;
    settle();
    rd(6'h28, v); chk("R9 timer bit", v, 32'h1);
    chk("R9 group0 line", {25'd0, irq_out}, 32'h40);
    wr(6'h28, 32'hFFFF_FFFF);
    @(negedge clk) cable_det_in = 1'b1;
    settle();
    rd(6'h28, v); chk("R9 cable bit", v, 32'h4);
    wr(6'h28, 32'h4);
    rd(6'h28, v); chk("R9 cable cleared", v, 32'd0);

    // R8 masked type write ignored
    wr(6'h39, 32'hFFFF_FFFF);
    rd(6'h39, v); chk("R8 type group1", v, 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule